// File: doc/BRIEF.md
# Dual Store Queue Burst Writer

This block gives a processor a fast path for writing a full 32-byte line to external memory without a cache. Two write-combining queues, each holding eight 32-bit words, are filled by ordinary word stores into a reserved address window. A flush command into the same window sends the contents of one queue to memory as a single aligned 32-byte burst of eight beats.

The two queues are meant to be used in turn. Software fills one queue while the other drains. A store or flush aimed at the queue that is draining is held on the CPU port until that queue's burst has ended. Work on the other queue goes ahead at full rate. The external burst address is built without translation. It joins the middle bits of the flush address, the queue number, and a 3-bit upper field that software loads per queue through a separate register-write port.

Top module: `sq_burst_writer`

## Requirements
- R1: A CPU command has an effect only when cpu_addr[31:26] is 6'b111000. Any other address is accepted in the same cycle (cpu_ready high), changes no queue contents and starts no burst.
- R2: A write (cpu_flush=0) stores cpu_wdata into queue cpu_addr[5] (0 selects queue 0, 1 selects queue 1) at word cpu_addr[4:2]. Bits [1:0] are ignored.
- R3: A flush (cpu_flush=1) produces exactly one burst of eight beats, carrying queue words 0 to 7 in that order. mem_last is high only on the eighth beat. A beat stays on the port, with mem_addr and mem_data stable, until mem_ready is seen high at a clock edge.
- R4: The burst address on mem_addr (29 bits, constant for the whole burst) is {upper[q], cpu_addr[25:6], q, 5'b00000}, where q = cpu_addr[5] of the flush.
- R5: Each queue has a 3-bit upper field, written by upw_value when upw_en is high, with upw_qsel picking the queue. A burst uses the value held when its flush was accepted. Later writes to the field do not alter it.
- R6: While one queue is draining, writes and flushes to the other queue are accepted with no wait cycle.
- R7: A write to a queue whose burst is queued or in progress holds cpu_ready low until the last beat of that burst completes. The write is accepted in a later cycle and never alters the burst data.
- R8: A flush to a queue whose burst is queued or in progress is stalled in the same way as R7.
- R9: When flushes of both queues are pending, their bursts are sent in the order the flushes were accepted.
- R10: After synchronous active-low reset, mem_valid is low, cpu_ready is high, and both upper fields are zero.
- R11: A flush does not clear a queue. A second flush with no writes in between sends the same eight words again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_valid | input | 1 | CPU command present |
| cpu_flush | input | 1 | 1: flush command, 0: word write |
| cpu_addr | input | 32 | Command address |
| cpu_wdata | input | 32 | Word to store |
| cpu_ready | output | 1 | Command accepted this cycle when high |
| upw_en | input | 1 | Upper-field register write strobe |
| upw_qsel | input | 1 | Queue whose upper field is written |
| upw_value | input | 3 | New upper field value |
| mem_valid | output | 1 | Burst beat present |
| mem_ready | input | 1 | Memory takes the beat at this edge |
| mem_addr | output | 29 | 32-byte-aligned burst start address |
| mem_data | output | 32 | Beat data |
| mem_last | output | 1 | Final beat of the burst |

## Verification
On every cycle the assertions check the following. A beat held under backpressure keeps its address and data. A queue being sent is always marked busy. A busy flag drops only on a completed final beat. No store lands in a locked queue. The pending-flush list never overflows or underflows. Matters that need a history of commands are shown only by the bench's scenarios against its reference model. These include word order, address assembly from the upper field captured at flush time, FIFO service of two pending flushes, the no-wait path to the idle queue, the ignoring of out-of-window commands, and the data retained after a flush.

// File: rtl/sqbw_pkg.sv
// Package: shared constants and the flush request record for the dual
// store queue burst writer. Field positions here are fixed by the
// command address layout that software uses.
package sqbw_pkg;
    localparam int SQ_NUM     = 2;
    localparam int WORD_W     = 32;
    localparam int SQ_WORDS   = 8;
    localparam int IDX_W      = $clog2(SQ_WORDS);
    localparam int UPPER_W    = 3;
    localparam int CPU_AW     = 32;
    localparam int LOW_W      = 5;
    localparam int QSEL_BIT   = 5;
    localparam int IDX_LSB    = 2;
    localparam int MID_LSB    = 6;
    localparam int MID_MSB    = 25;
    localparam int MID_W      = MID_MSB - MID_LSB + 1;
    localparam int TAG_LSB    = 26;
    localparam int TAG_W      = 6;
    localparam logic [TAG_W-1:0] WINDOW_TAG = 6'b111000;
    localparam int EXT_AW     = UPPER_W + MID_W + 1 + LOW_W;

    typedef struct packed {
        logic               qid;
        logic [UPPER_W-1:0] upper;
        logic [MID_W-1:0]   mid;
    } flush_req_t;

    localparam int REQ_W = $bits(flush_req_t);

    // Assemble the aligned external burst address from a request.
    function automatic logic [EXT_AW-1:0] burst_addr(input flush_req_t r);
        return {r.upper, r.mid, r.qid, {LOW_W{1'b0}}};
    endfunction
endpackage

// File: rtl/sqbw_queue_store.sv
// Module: one write-combining queue of DEPTH words.
// Writes land at wr_idx. The burst engine reads any word combinationally
// through rd_idx. Assumes the caller never writes while 'locked'
// (the queue is queued for or in a burst). Contents persist across flushes.
module sqbw_queue_store #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [$clog2(DEPTH)-1:0]   wr_idx,
    input  logic [WORD_W-1:0]          wr_data,
    input  logic                       locked,
    input  logic [$clog2(DEPTH)-1:0]   rd_idx,
    output logic [WORD_W-1:0]          rd_data
);
    logic [WORD_W-1:0] words [DEPTH];

    // Store one word, clearing everything on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                words[i] <= '0;
            end
        end else if (wr_en) begin
            words[wr_idx] <= wr_data;
        end
    end

    // Present the word the burst engine is sending.
    assign rd_data = words[rd_idx];

    // R7: a queue owned by a burst must never be overwritten.
    assert_no_write_while_draining_R7: assert property (
        @(posedge clk) disable iff (!rst_n) wr_en |-> !locked
    ) else $error("write into locked queue");
endmodule

// File: rtl/sqbw_flush_order.sv
// Module: small FIFO of accepted flush requests. The head entry is the
// burst being sent. The entries behind it wait in acceptance order.
// Assumes the caller never pushes when full or pops when empty. Push and
// pop may happen in the same cycle.
module sqbw_flush_order #(
    parameter int ENTRY_W = 24,
    parameter int DEPTH   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic [ENTRY_W-1:0] push_data,
    input  logic               pop,
    output logic               not_empty,
    output logic [ENTRY_W-1:0] head
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [ENTRY_W-1:0] slots [DEPTH];
    logic [PTR_W-1:0]   wr_ptr, rd_ptr;
    logic [CNT_W-1:0]   count;
    logic               full;

    // Advance a pointer with wrap at DEPTH.
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign full      = (count == CNT_W'(DEPTH));
    assign not_empty = (count != '0);
    assign head      = slots[rd_ptr];

    // Write the new request into the tail slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                slots[i] <= '0;
            end
        end else if (push) begin
            slots[wr_ptr] <= push_data;
        end
    end

    // Track pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            if (push && !pop)      count <= count + CNT_W'(1);
            else if (pop && !push) count <= count - CNT_W'(1);
        end
    end

    // R9: ordering relies on no request ever being dropped.
    assert_no_overflow_R9: assert property (
        @(posedge clk) disable iff (!rst_n) push |-> (!full || pop)
    ) else $error("flush order list overflow");

    // R3: a burst may only finish when one was started.
    assert_no_underflow_R3: assert property (
        @(posedge clk) disable iff (!rst_n) pop |-> not_empty
    ) else $error("flush order list underflow");
endmodule

// File: rtl/sqbw_burst_engine.sv
// Module: sends the head flush request as BEATS consecutive words with
// valid/ready handshakes. It selects the queue word through beat_qid and
// beat_idx and flags the final beat. Assumes the request stays at the head
// until 'done'.
module sqbw_burst_engine
    import sqbw_pkg::*;
#(
    parameter int BEATS   = 8,
    parameter int DATA_W  = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  flush_req_t                req_head,
    input  logic [DATA_W-1:0]         beat_data,
    output logic                      beat_qid,
    output logic [$clog2(BEATS)-1:0]  beat_idx,
    output logic                      mem_valid,
    input  logic                      mem_ready,
    output logic [EXT_AW-1:0]         mem_addr,
    output logic [DATA_W-1:0]         mem_data,
    output logic                      mem_last,
    output logic                      done
);
    localparam int CNT_W = $clog2(BEATS);

    logic [CNT_W-1:0] cnt;
    logic             fire;

    // Drive the beat from the head request and current word count.
    always_comb begin
        mem_valid = req_valid;
        mem_addr  = burst_addr(req_head);
        mem_data  = beat_data;
        mem_last  = (cnt == CNT_W'(BEATS - 1));
        beat_qid  = req_head.qid;
        beat_idx  = cnt;
        fire      = mem_valid && mem_ready;
        done      = fire && mem_last;
    end

    // Step through the words on each accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (fire) begin
            cnt <= mem_last ? '0 : cnt + CNT_W'(1);
        end
    end

    // R3: a stalled beat keeps its address and data.
    assert_beat_held_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data))
    ) else $error("beat changed under backpressure");

    // R3: the final-beat flag is not withdrawn while stalled.
    assert_last_held_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_last && !mem_ready) |=> mem_last
    ) else $error("last flag dropped while stalled");
endmodule

// File: rtl/sq_burst_writer.sv
// Module: top of the dual store queue burst writer. It decodes CPU
// commands in the reserved window, steers writes into the two queues,
// holds per-queue busy flags and upper-address fields, and orders flushes
// into the burst engine. Assumes at most one CPU command per cycle. A
// command is taken on the edge where cpu_valid and cpu_ready are both high.
module sq_burst_writer
    import sqbw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cpu_valid,
    input  logic                 cpu_flush,
    input  logic [CPU_AW-1:0]    cpu_addr,
    input  logic [WORD_W-1:0]    cpu_wdata,
    output logic                 cpu_ready,
    input  logic                 upw_en,
    input  logic                 upw_qsel,
    input  logic [UPPER_W-1:0]   upw_value,
    output logic                 mem_valid,
    input  logic                 mem_ready,
    output logic [EXT_AW-1:0]    mem_addr,
    output logic [WORD_W-1:0]    mem_data,
    output logic                 mem_last
);
    logic                  in_window;
    logic                  qsel;
    logic [IDX_W-1:0]      widx;
    logic [SQ_NUM-1:0]     sel_oh;
    logic [SQ_NUM-1:0]     q_busy;
    logic                  take, wr_take, fl_take;
    logic [UPPER_W-1:0]    upper_r [SQ_NUM];
    flush_req_t            new_req;
    flush_req_t            head_req;
    logic [REQ_W-1:0]      head_bits;
    logic                  head_valid;
    logic                  beat_qid;
    logic [IDX_W-1:0]      beat_idx;
    logic [WORD_W-1:0]     rd_word [SQ_NUM];
    logic                  done;
    logic                  unused_low;

    // Decode the command address and decide whether to accept it.
    always_comb begin
        in_window = (cpu_addr[TAG_LSB +: TAG_W] == WINDOW_TAG);
        qsel      = cpu_addr[QSEL_BIT];
        widx      = cpu_addr[IDX_LSB +: IDX_W];
        sel_oh    = SQ_NUM'(1) << qsel;
        cpu_ready = !(cpu_valid && in_window && q_busy[qsel]);
        take      = cpu_valid && in_window && !q_busy[qsel];
        wr_take   = take && !cpu_flush;
        fl_take   = take && cpu_flush;
        new_req.qid   = qsel;
        new_req.upper = upper_r[qsel];
        new_req.mid   = cpu_addr[MID_MSB:MID_LSB];
    end

    assign unused_low = ^cpu_addr[IDX_LSB-1:0];

    // Hold the per-queue upper address fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SQ_NUM; i++) begin
                upper_r[i] <= '0;
            end
        end else if (upw_en) begin
            upper_r[upw_qsel] <= upw_value;
        end
    end

    // Mark a queue busy from flush acceptance until its final beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_busy <= '0;
        end else begin
            q_busy <= (q_busy | (fl_take ? sel_oh : '0))
                      & ~(done ? (SQ_NUM'(1) << beat_qid) : '0);
        end
    end

    // One storage block per queue.
    for (genvar gi = 0; gi < SQ_NUM; gi++) begin : g_queue
        sqbw_queue_store #(
            .WORD_W (WORD_W),
            .DEPTH  (SQ_WORDS)
        ) store_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_take && sel_oh[gi]),
            .wr_idx  (widx),
            .wr_data (cpu_wdata),
            .locked  (q_busy[gi]),
            .rd_idx  (beat_idx),
            .rd_data (rd_word[gi])
        );

        // R7: a busy flag clears only on this queue's completed final beat.
        assert_busy_clears_on_last_R7: assert property (
            @(posedge clk) disable iff (!rst_n)
            $fell(q_busy[gi]) |-> $past(mem_valid && mem_ready && mem_last
                                        && (mem_addr[QSEL_BIT] == 1'(gi)))
        ) else $error("busy flag cleared without a final beat");
    end

    sqbw_flush_order #(
        .ENTRY_W (REQ_W),
        .DEPTH   (SQ_NUM)
    ) order_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fl_take),
        .push_data (new_req),
        .pop       (done),
        .not_empty (head_valid),
        .head      (head_bits)
    );

    assign head_req = flush_req_t'(head_bits);

    sqbw_burst_engine #(
        .BEATS  (SQ_WORDS),
        .DATA_W (WORD_W)
    ) engine_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (head_valid),
        .req_head  (head_req),
        .beat_data (rd_word[beat_qid]),
        .beat_qid  (beat_qid),
        .beat_idx  (beat_idx),
        .mem_valid (mem_valid),
        .mem_ready (mem_ready),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .mem_last  (mem_last),
        .done      (done)
    );

    // R8: the queue being sent is always held busy.
    assert_sending_queue_busy_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        mem_valid |-> q_busy[mem_addr[QSEL_BIT]]
    ) else $error("burst from a queue not marked busy");
endmodule

// File: tb/sq_burst_writer_tb_top.sv
// Bench: directed corner cases plus seeded random traffic, checked against
// a reference model of the queues, upper fields and expected bursts.
module sq_burst_writer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_valid = 1'b0, cpu_flush = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic        cpu_ready;
    logic        upw_en = 1'b0, upw_qsel = 1'b0;
    logic [2:0]  upw_value = '0;
    logic        mem_valid, mem_ready = 1'b0, mem_last;
    logic [28:0] mem_addr;
    logic [31:0] mem_data;

    int errors = 0, checks = 0, cyc = 0, rmode = 2, beat = 0, stalls = 0;
    bit hold = 0;
    logic [28:0] hold_addr;
    logic [31:0] hold_data;
    logic [31:0] m_q [2][8];
    logic [2:0]  m_up [2];
    logic [28:0]  e_addr [$];
    logic [255:0] e_data [$];

    sq_burst_writer dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_flush(cpu_flush),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
        .upw_en(upw_en), .upw_qsel(upw_qsel), .upw_value(upw_value),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_last(mem_last)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] win_addr(input bit q, input int idx, input logic [19:0] mid);
        return {6'b111000, mid, q, 3'(idx), 2'b00};
    endfunction

    function automatic bit pending_for(input bit q);
        foreach (e_addr[k]) if (e_addr[k][5] == q) return 1;
        return 0;
    endfunction

    // Memory-side responder: choose ready just after each edge.
    always @(posedge clk) begin
        #1;
        mem_ready = (rmode == 1) || (rmode == 0 && ($urandom % 4) != 0);
    end

    // Monitor: compare each completed beat with the expected burst list.
    always @(negedge clk) begin
        if (!rst_n) begin
            beat = 0;
            hold = 0;
        end else begin
            if (hold)
                check(mem_valid && mem_addr == hold_addr && mem_data == hold_data, "R3",
                      "beat held under backpressure", {mem_valid, mem_data}, {1'b1, hold_data});
            if (mem_valid && mem_ready) begin
                if (e_addr.size() == 0) begin
                    check(0, "R1", "beat with no accepted flush", 64'(mem_addr), 64'h0);
                end else begin
                    logic [255:0] cur;
                    cur = e_data[0];
                    check(mem_addr == e_addr[0], "R4", "burst address (order R9)", 64'(mem_addr), 64'(e_addr[0]));
                    check(mem_data == cur[beat*32 +: 32], "R3", "beat word", 64'(mem_data), 64'(cur[beat*32 +: 32]));
                    check(mem_last == (beat == 7), "R3", "last flag", 64'(mem_last), 64'(beat == 7));
                    beat++;
                    if (beat == 8) begin
                        beat = 0;
                        void'(e_addr.pop_front());
                        void'(e_data.pop_front());
                    end
                end
            end
            hold = mem_valid && !mem_ready;
            hold_addr = mem_addr;
            hold_data = mem_data;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            check(0, "R3", "watchdog cycles", 64'(cyc), 64'(WATCHDOG));
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Issue one CPU command; it is taken on the edge after ready is seen.
    task automatic cpu_op(input bit fl, input logic [31:0] a, input logic [31:0] d);
        logic [255:0] snap;
        @(posedge clk); #1;
        cpu_valid = 1'b1; cpu_flush = fl; cpu_addr = a; cpu_wdata = d;
        stalls = 0;
        forever begin
            @(negedge clk);
            if (cpu_ready) break;
            stalls++;
        end
        if (a[31:26] == 6'b111000) begin
            if (!fl) begin
                check(!pending_for(a[5]), "R7", "write taken while queue draining", 64'(a), 64'h0);
                m_q[a[5]][a[4:2]] = d;
            end else begin
                check(!pending_for(a[5]), "R8", "flush taken while queue draining", 64'(a), 64'h0);
                for (int i = 0; i < 8; i++) snap[i*32 +: 32] = m_q[a[5]][i];
                e_addr.push_back({m_up[a[5]], a[25:6], a[5], 5'b0});
                e_data.push_back(snap);
            end
        end else begin
            check(stalls == 0, "R1", "out-of-window command stalled", 64'(stalls), 64'h0);
        end
    endtask

    task automatic idle();
        @(posedge clk); #1;
        cpu_valid = 1'b0;
    endtask

    task automatic upw(input bit q, input logic [2:0] v);
        @(posedge clk); #1;
        cpu_valid = 1'b0; upw_en = 1'b1; upw_qsel = q; upw_value = v;
        @(posedge clk); #1;
        upw_en = 1'b0;
        m_up[q] = v;
    endtask

    task automatic drain();
        idle();
        while (e_addr.size() != 0 || mem_valid) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h5EED1234));
        for (int q = 0; q < 2; q++) begin
            m_up[q] = '0;
            for (int i = 0; i < 8; i++) m_q[q][i] = '0;
        end
        repeat (3) @(negedge clk);
        check(mem_valid == 1'b0, "R10", "mem_valid in reset", 64'(mem_valid), 64'h0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check(mem_valid == 1'b0 && cpu_ready == 1'b1, "R10", "idle after reset",
              {mem_valid, cpu_ready}, 64'h1);

        // R2: fill both queues with distinct words, memory held off.
        rmode = 2;
        for (int q = 0; q < 2; q++)
            for (int i = 0; i < 8; i++)
                cpu_op(0, win_addr(q[0], i, 20'h0), 32'hA000_0000 + q * 16 + i);
        cpu_op(1, win_addr(0, 0, 20'h12345), 32'h0);
        idle();
        @(negedge clk);
        check(mem_valid && mem_addr[28:26] == 3'd0, "R10", "upper field zero after reset",
              64'(mem_addr), {35'h0, 3'd0, 20'h12345, 6'h0});
        cpu_op(0, win_addr(1, 3, 20'h0), 32'hB0B0_0003);
        check(stalls == 0, "R6", "write to idle queue while other drains", 64'(stalls), 64'h0);
        cpu_op(1, win_addr(1, 0, 20'h00F0F), 32'h0);
        check(stalls == 0, "R6", "flush of idle queue while other drains", 64'(stalls), 64'h0);
        rmode = 1;
        cpu_op(0, win_addr(0, 5, 20'h0), 32'hC0C0_0005);
        check(stalls > 0, "R7", "write to draining queue stalled", 64'(stalls), 64'h1);
        cpu_op(1, win_addr(1, 0, 20'h00ABC), 32'h0);
        check(stalls > 0, "R8", "flush of draining queue stalled", 64'(stalls), 64'h1);
        drain();

        // R5: upper fields, and capture at flush acceptance.
        upw(0, 3'd5);
        upw(1, 3'd2);
        rmode = 2;
        cpu_op(1, win_addr(0, 0, 20'h55555), 32'h0);
        upw(0, 3'd7);
        @(negedge clk);
        check(mem_valid && mem_addr[28:26] == 3'd5, "R5", "upper field captured at flush",
              64'(mem_addr[28:26]), 64'd5);
        rmode = 1;
        cpu_op(1, win_addr(1, 0, 20'hAAAAA), 32'h0);
        drain();

        // R1: out-of-window commands change nothing.
        cpu_op(0, 32'hE400_0000, 32'hDEAD_BEEF);
        cpu_op(1, 32'hE400_0000, 32'h0);
        cpu_op(0, 32'h6000_0024, 32'hDEAD_0001);
        drain();
        check(e_addr.size() == 0 && !mem_valid, "R1", "no burst from out-of-window flush",
              64'(mem_valid), 64'h0);
        cpu_op(1, win_addr(0, 0, 20'h00001), 32'h0);
        rmode = 2;
        cpu_op(1, win_addr(1, 0, 20'h00002), 32'h0);
        cpu_op(0, 32'hF000_0020, 32'h1111_2222);
        rmode = 1;
        drain();

        // R11: flush again with no writes: same words.
        cpu_op(1, win_addr(1, 0, 20'h00003), 32'h0);
        drain();

        // Random traffic.
        for (int n = 0; n < 400; n++) begin
            int op;
            op = $urandom % 9;
            rmode = ($urandom % 3 == 0) ? 0 : ($urandom % 2 == 0 ? 1 : 0);
            if (op < 5) begin
                cpu_op(0, win_addr(1'($urandom), $urandom % 8, 20'($urandom)), $urandom);
            end else if (op < 7) begin
                cpu_op(1, win_addr(1'($urandom), $urandom % 8, 20'($urandom)), 32'h0);
            end else if (op == 7) begin
                logic [5:0] tag;
                tag = 6'($urandom);
                if (tag == 6'b111000) tag = 6'b111001;
                cpu_op(1'($urandom), {tag, 26'($urandom)} & 32'hFFFF_FFFC, $urandom);
            end else begin
                upw(1'($urandom), 3'($urandom));
            end
        end
        rmode = 1;
        drain();
        check(e_addr.size() == 0, "R3", "every flush sent as one burst", 64'(e_addr.size()), 64'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule